// File: doc/BRIEF.md
# Multi-buffer DMA channel sequencer

One DMA channel that copies a series of equal-sized buffers from a source region to a destination region over a simple word-wide memory port. Each word takes one beat: a read cycle on the source address, then a write cycle that stores the returned word at the destination address. Both addresses then advance by one. When a new buffer begins, each address either returns to its programmed base or carries on from where the previous buffer ended. This choice is made separately for source and destination by two reload bits.

Software starts the channel with an enable strobe. At every buffer boundary the interrupt-enable input selects what happens next. When it is set, the channel raises a sticky buffer-complete flag and stalls until a keep-on strobe arrives. When it is clear, the channel starts the next buffer at once. While the automatic-mode bit is held, buffers repeat without limit. Clearing it before a buffer's last write makes that buffer the final one. A disable strobe aborts the channel at a beat boundary.

Top module: `mbuf_dma_seq`

## Requirements
- R1: After reset, enabled_o, stalled_o, irq_o, rd_en_o and wr_en_o are all 0.
- R2: An en_set_i pulse while the channel is idle raises enabled_o and rd_en_o on the next cycle.
  - Each buffer moves buf_len_i words (buf_len_i >= 1).
  - Each word is a read cycle at the source pointer followed by a write cycle of rd_data_i at the destination pointer.
  - rd_data_i is the word returned one cycle after the read.
  - Both pointers start at src_base_i and dst_base_i and increase by 1 per word.
- R3: enabled_o stays 1 through the whole multi-buffer transfer, including stalls. It returns to 0 in the cycle after the final buffer's last write.
- R4: At the start of each buffer after the first, the source pointer reloads src_base_i if src_rld_i=1 and otherwise continues at the next address. The destination pointer does the same, using dst_base_i and dst_rld_i.
- R5: With irq_en_i=1, the last write of every buffer sets irq_o, the final buffer included. If the buffer is not final, stalled_o goes to 1 and no read or write occurs until the channel resumes.
- R6: A keep_on_i pulse while stalled clears stalled_o on the next cycle and starts the next buffer with a read in that same cycle.
- R7: With irq_en_i=0, the next buffer starts on the cycle after the previous buffer's last write. stalled_o stays 0 and irq_o is not set.
- R8: If auto_i is 0 during a buffer's last write, that buffer is final and the channel disables itself. While auto_i stays 1, buffers repeat.
- R9: en_set_i while enabled_o=1 has no effect: the transfer neither restarts nor lengthens.
- R10: keep_on_i has no effect unless the channel is stalled.
- R11: irq_o stays set until an irq_clr_i pulse. If a set and a clear arrive in the same cycle, the set wins.
- R12: An en_clr_i pulse aborts the channel, which returns to idle with enabled_o=0 and does not set irq_o.
  - In a write cycle, that write completes and no further beat follows.
  - In a read cycle, the beat's write still occurs, and then the channel stops.
  - While stalled, the channel goes idle on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_base_i | input | AW | Source base address |
| dst_base_i | input | AW | Destination base address |
| buf_len_i | input | LW | Words per buffer, at least 1 |
| auto_i | input | 1 | Automatic mode: 1 continues with another buffer |
| src_rld_i | input | 1 | Reload source pointer at each new buffer |
| dst_rld_i | input | 1 | Reload destination pointer at each new buffer |
| irq_en_i | input | 1 | Buffer-complete interrupt unmasked; selects stalling |
| en_set_i | input | 1 | Start strobe |
| en_clr_i | input | 1 | Disable (abort) strobe |
| keep_on_i | input | 1 | Resume strobe for a stalled channel |
| irq_clr_i | input | 1 | Clear strobe for irq_o |
| rd_en_o | output | 1 | Memory read request |
| rd_addr_o | output | AW | Read address |
| rd_data_i | input | DW | Read data, valid one cycle after rd_en_o |
| wr_en_o | output | 1 | Memory write request |
| wr_addr_o | output | AW | Write address |
| wr_data_o | output | DW | Write data |
| enabled_o | output | 1 | Transfer in progress |
| stalled_o | output | 1 | Halted at a buffer boundary |
| irq_o | output | 1 | Sticky buffer-complete flag |

## Verification
The properties assume that the memory returns read data exactly one cycle after a read request. They also assume that buf_len_i is never 0 and does not change while a transfer is in progress.

The bench keeps buf_len_i, the base addresses and the reload bits constant from each start strobe until the channel is idle again. The only exceptions are auto_i, which is dropped on purpose inside a chosen buffer, and the strobes. Its memory model always answers on the following cycle.

// File: rtl/mbuf_dma_pkg.sv
package mbuf_dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_STALL = 2'd3
  } seq_st_e;
endpackage

// File: rtl/mbuf_dma_ptr.sv
module mbuf_dma_ptr #(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] base_i,
  input  logic          rld_en_i,
  input  logic          load_i,
  input  logic          nxt_buf_i,
  input  logic          step_i,
  output logic [AW-1:0] ptr_o
);
  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     ptr_q <= '0;
    else if (load_i)                 ptr_q <= base_i;
    else if (nxt_buf_i && rld_en_i)  ptr_q <= base_i;
    else if (step_i)                 ptr_q <= ptr_q + AW'(1);
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/mbuf_dma_beat_cnt.sv
module mbuf_dma_beat_cnt #(
  parameter int LW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [LW-1:0] len_i,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic          last_o
);
  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + LW'(1);
  end

  assign last_o = (cnt_q == len_i - LW'(1));
endmodule

// File: rtl/mbuf_dma_fsm.sv
module mbuf_dma_fsm
  import mbuf_dma_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_set_i,
  input  logic en_clr_i,
  input  logic keep_on_i,
  input  logic auto_i,
  input  logic irq_en_i,
  input  logic last_i,
  output logic start_o,
  output logic step_o,
  output logic nxt_buf_o,
  output logic cnt_clr_o,
  output logic irq_set_o,
  output logic rd_en_o,
  output logic wr_en_o,
  output logic enabled_o,
  output logic stalled_o
);
  seq_st_e st_q, st_d;
  logic    abort_q;
  logic    abort_now;
  logic    buf_done;

  assign abort_now = abort_q | en_clr_i;
  assign buf_done  = (st_q == ST_WRITE) && last_i && !abort_now;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (en_set_i) st_d = ST_READ;
      ST_READ:  st_d = ST_WRITE;
      ST_WRITE: begin
        if (abort_now)      st_d = ST_IDLE;
        else if (!last_i)   st_d = ST_READ;
        else if (!auto_i)   st_d = ST_IDLE;
        else if (irq_en_i)  st_d = ST_STALL;
        else                st_d = ST_READ;
      end
      ST_STALL: begin
        if (en_clr_i)       st_d = ST_IDLE;
        else if (keep_on_i) st_d = ST_READ;
      end
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      abort_q <= 1'b0;
    end else begin
      st_q <= st_d;
      // a disable seen in the read cycle lets the beat's write finish
      if (st_q == ST_READ) abort_q <= abort_q | en_clr_i;
      else                 abort_q <= 1'b0;
    end
  end

  assign start_o   = (st_q == ST_IDLE) && en_set_i;
  assign step_o    = (st_q == ST_WRITE);
  assign cnt_clr_o = start_o | buf_done;
  assign irq_set_o = buf_done && irq_en_i;
  assign nxt_buf_o = (buf_done && auto_i && !irq_en_i) ||
                     ((st_q == ST_STALL) && keep_on_i && !en_clr_i);
  assign rd_en_o   = (st_q == ST_READ);
  assign wr_en_o   = (st_q == ST_WRITE);
  assign enabled_o = (st_q != ST_IDLE);
  assign stalled_o = (st_q == ST_STALL);
endmodule

// File: rtl/mbuf_dma_seq.sv
module mbuf_dma_seq #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int LW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] src_base_i,
  input  logic [AW-1:0] dst_base_i,
  input  logic [LW-1:0] buf_len_i,
  input  logic          auto_i,
  input  logic          src_rld_i,
  input  logic          dst_rld_i,
  input  logic          irq_en_i,
  input  logic          en_set_i,
  input  logic          en_clr_i,
  input  logic          keep_on_i,
  input  logic          irq_clr_i,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [DW-1:0] rd_data_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          enabled_o,
  output logic          stalled_o,
  output logic          irq_o
);
  localparam int NPTR = 2;  // 0: source, 1: destination

  logic start, step, nxt_buf, cnt_clr, irq_set, last;
  logic [NPTR-1:0][AW-1:0] base, ptr;
  logic [NPTR-1:0]         rld;
  logic                    irq_q;

  assign base = {dst_base_i, src_base_i};
  assign rld  = {dst_rld_i, src_rld_i};

  mbuf_dma_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_set_i  (en_set_i),
    .en_clr_i  (en_clr_i),
    .keep_on_i (keep_on_i),
    .auto_i    (auto_i),
    .irq_en_i  (irq_en_i),
    .last_i    (last),
    .start_o   (start),
    .step_o    (step),
    .nxt_buf_o (nxt_buf),
    .cnt_clr_o (cnt_clr),
    .irq_set_o (irq_set),
    .rd_en_o   (rd_en_o),
    .wr_en_o   (wr_en_o),
    .enabled_o (enabled_o),
    .stalled_o (stalled_o)
  );

  mbuf_dma_beat_cnt #(.LW(LW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .len_i  (buf_len_i),
    .clr_i  (cnt_clr),
    .inc_i  (step),
    .last_o (last)
  );

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    mbuf_dma_ptr #(.AW(AW)) u_ptr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .base_i    (base[g]),
      .rld_en_i  (rld[g]),
      .load_i    (start),
      .nxt_buf_i (nxt_buf),
      .step_i    (step),
      .ptr_o     (ptr[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_q <= 1'b0;
    else if (irq_set)   irq_q <= 1'b1;
    else if (irq_clr_i) irq_q <= 1'b0;
  end

  assign rd_addr_o = ptr[0];
  assign wr_addr_o = ptr[1];
  assign wr_data_o = rd_data_i;
  assign irq_o     = irq_q;
endmodule

// File: rtl/mbuf_dma_seq_chk.sv
module mbuf_dma_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic irq_en_i,
  input logic en_set_i,
  input logic en_clr_i,
  input logic keep_on_i,
  input logic irq_clr_i,
  input logic rd_en_o,
  input logic wr_en_o,
  input logic enabled_o,
  input logic stalled_o,
  input logic irq_o
);
  a_r2_write_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(rd_en_o));

  a_r2_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enabled_o && en_set_i |=> enabled_o && rd_en_o);

  a_r5_stall_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stalled_o |-> !rd_en_o && !wr_en_o);

  a_r5_stall_raises_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stalled_o) |-> irq_o);

  a_r6_resume: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stalled_o && keep_on_i && !en_clr_i |=> !stalled_o && rd_en_o);

  a_r6_hold_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stalled_o && !keep_on_i && !en_clr_i |=> stalled_o);

  a_r7_masked_no_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |=> !$rose(stalled_o));

  a_r11_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !irq_clr_i |=> irq_o);

  a_r12_stall_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stalled_o && en_clr_i |=> !enabled_o);

  a_r10_idle_keep_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enabled_o && !en_set_i && keep_on_i |=> !enabled_o);
endmodule

bind mbuf_dma_seq mbuf_dma_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .irq_en_i  (irq_en_i),
  .en_set_i  (en_set_i),
  .en_clr_i  (en_clr_i),
  .keep_on_i (keep_on_i),
  .irq_clr_i (irq_clr_i),
  .rd_en_o   (rd_en_o),
  .wr_en_o   (wr_en_o),
  .enabled_o (enabled_o),
  .stalled_o (stalled_o),
  .irq_o     (irq_o)
);

// File: tb/mbuf_dma_seq_test.sv
module mbuf_dma_seq_test;
  localparam int AW = 16, DW = 32, LW = 8, LOGN = 512;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] src_base = '0, dst_base = '0;
  logic [LW-1:0] buf_len = 8'd1;
  logic auto_b = 0, src_rld = 0, dst_rld = 0, irq_en = 0;
  logic en_set = 0, en_clr = 0, keep_on = 0, irq_clr = 0;
  logic rd_en, wr_en, enabled, stalled, irq;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] rd_data = '0, wr_data;

  int n_chk = 0, n_fail = 0, nlog = 0;
  logic [AW-1:0] log_a [LOGN];
  logic [DW-1:0] log_d [LOGN];
  bit stall_seen = 0;

  mbuf_dma_seq #(.AW(AW), .DW(DW), .LW(LW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .src_base_i(src_base), .dst_base_i(dst_base),
    .buf_len_i(buf_len), .auto_i(auto_b), .src_rld_i(src_rld), .dst_rld_i(dst_rld),
    .irq_en_i(irq_en), .en_set_i(en_set), .en_clr_i(en_clr), .keep_on_i(keep_on),
    .irq_clr_i(irq_clr), .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .enabled_o(enabled), .stalled_o(stalled), .irq_o(irq));

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] mem_word(logic [AW-1:0] a);
    return {~a, a};
  endfunction

  always @(posedge clk) if (rd_en) rd_data <= mem_word(rd_addr);

  always @(negedge clk) begin
    if (wr_en && nlog < LOGN) begin
      log_a[nlog] = wr_addr;
      log_d[nlog] = wr_data;
      nlog++;
    end
    if (stalled) stall_seen = 1;
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; tick(); s = 1'b0;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 4000 && enabled; n++) tick();
  endtask

  task automatic wait_writes(int k);
    for (int n = 0; n < 4000 && nlog < k; n++) tick();
  endtask

  task automatic wait_stall();
    for (int n = 0; n < 4000 && !stalled; n++) tick();
  endtask

  task automatic setup(logic [AW-1:0] s, logic [AW-1:0] d, int l, bit sr, bit dr,
                       bit ie, bit au);
    src_base = s; dst_base = d; buf_len = LW'(l);
    src_rld = sr; dst_rld = dr; irq_en = ie; auto_b = au;
    nlog = 0; stall_seen = 0;
  endtask

  task automatic verify(string req, int l, int nb);
    chk(nlog == l * nb, req, nlog, l * nb);
    for (int b = 0; b < nb; b++)
      for (int i = 0; i < l; i++) begin
        int e = b * l + i;
        logic [AW-1:0] sa = src_base + AW'(src_rld ? i : e);
        logic [AW-1:0] da = dst_base + AW'(dst_rld ? i : e);
        if (e < nlog) begin
          chk(log_a[e] == da, req, log_a[e], da);
          chk(log_d[e] == mem_word(sa), req, log_d[e], mem_word(sa));
        end
      end
  endtask

  // masked run of nb buffers, auto dropped inside buffer nb
  task automatic run_masked(string req, logic [AW-1:0] s, logic [AW-1:0] d, int l,
                            bit sr, bit dr, int nb);
    setup(s, d, l, sr, dr, 1'b0, nb > 1);
    pulse(en_set);
    if (nb > 1) begin
      wait_writes((nb - 1) * l);
      tick();
      auto_b = 0;
    end
    wait_idle();
    tick();
    verify(req, l, nb);
    chk(!stall_seen, {req, " no stall (R7)"}, stall_seen, 0);
    chk(!irq, {req, " irq clear (R7)"}, irq, 0);
  endtask

  initial begin
    #1_500_000;
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    tick(); tick();
    // R1 reset state
    chk({enabled, stalled, irq, rd_en, wr_en} == 5'b0, "R1 reset outputs",
        {enabled, stalled, irq, rd_en, wr_en}, 0);
    rst_n = 1'b1;
    tick();

    // R10 keep-on while idle
    pulse(keep_on); tick();
    chk(!enabled && nlog == 0, "R10 keep_on idle", enabled, 0);

    // R2 R3 R5 single buffer, unmasked, final
    setup(16'h0100, 16'h0800, 5, 1, 1, 1, 0);
    pulse(en_set);
    chk(enabled && rd_en, "R2 start", {enabled, rd_en}, 2'b11);
    chk(rd_addr == 16'h0100, "R2 first read addr", rd_addr, 16'h0100);
    wait_writes(3);
    chk(enabled, "R3 enabled mid buffer", enabled, 1);
    wait_idle();
    chk(nlog == 5 && !enabled, "R3 idle after final", nlog, 5);
    verify("R2 single buffer", 5, 1);
    chk(irq && !stalled, "R5 irq on final buffer", {irq, stalled}, 2'b10);
    pulse(irq_clr);
    chk(!irq, "R11 irq clear", irq, 0);

    // R5 R6 R11 stall and resume
    setup(16'h2000, 16'h3000, 4, 1, 1, 1, 1);
    pulse(en_set);
    wait_stall();
    chk(stalled && enabled && irq, "R5 stalled with irq", {stalled, enabled, irq}, 3'b111);
    chk(nlog == 4, "R5 one buffer before stall", nlog, 4);
    for (int k = 0; k < 6; k++) tick();
    chk(nlog == 4 && stalled, "R5 stall holds", nlog, 4);
    chk(irq, "R11 irq sticky", irq, 1);
    pulse(irq_clr);
    chk(!irq, "R11 irq cleared in stall", irq, 0);
    pulse(keep_on);
    chk(!stalled && rd_en, "R6 resume", {stalled, rd_en}, 2'b01);
    chk(rd_addr == 16'h2000, "R4 source reload on resume", rd_addr, 16'h2000);
    auto_b = 0;
    wait_idle();
    tick();
    verify("R8 final after resume", 4, 2);
    chk(irq, "R5 irq on final", irq, 1);
    pulse(irq_clr);

    // R12 abort while stalled
    setup(16'h0040, 16'h0060, 2, 1, 1, 1, 1);
    pulse(en_set);
    wait_stall();
    pulse(en_clr);
    chk(!enabled && !stalled, "R12 abort from stall", {enabled, stalled}, 0);
    pulse(irq_clr);

    // R12 abort during write beat
    setup(16'h0500, 16'h0600, 8, 1, 1, 1, 0);
    pulse(en_set);
    wait_writes(3);
    pulse(en_clr);
    for (int k = 0; k < 4; k++) tick();
    chk(nlog == 3 && !enabled, "R12 abort stops at beat", nlog, 3);
    chk(!irq, "R12 abort sets no irq", irq, 0);

    // R12 abort during read beat: that beat's write still lands
    setup(16'h0700, 16'h0780, 8, 1, 1, 0, 0);
    pulse(en_set);
    wait_writes(2);
    tick();
    pulse(en_clr);
    for (int k = 0; k < 4; k++) tick();
    chk(nlog == 3 && !enabled, "R12 abort in read", nlog, 3);

    // R9 R10 strobes while running
    setup(16'h1000, 16'h1100, 6, 1, 1, 0, 0);
    pulse(en_set);
    wait_writes(2);
    pulse(keep_on);
    wait_writes(3);
    pulse(en_set);
    wait_idle();
    tick();
    verify("R9 R10 busy strobes ignored", 6, 1);

    // R4 R7 R8 masked multi-buffer
    run_masked("R8 three reloaded buffers", 16'h4000, 16'h5000, 3, 1, 1, 3);
    run_masked("R4 source continues", 16'h4100, 16'h5100, 4, 0, 1, 2);
    run_masked("R4 destination continues", 16'h4200, 16'h5200, 2, 1, 0, 3);
    run_masked("R7 single-word buffers", 16'h4300, 16'h5300, 1, 1, 1, 3);

    // random masked runs
    for (int it = 0; it < 8; it++) begin
      int l = 1 + int'($urandom % 8);
      int nb = 1 + int'($urandom % 3);
      run_masked("R4 R8 random", AW'($urandom), AW'($urandom), l,
                 bit'($urandom % 2), bit'($urandom % 2), nb);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule